// File: doc/BRIEF.md
# Search Bus Chain Controller

This block is the master of a shared bus that serves any number of key-search slave chips. It writes to the slaves over a 16-bit data bus with a write strobe and reads from them with a read strobe. A global select line lets it write the same parameters, such as plaintext and ciphertext, to every chip at once. To reach one chip at a time it uses no address decoding. It shifts a single 1 through a chain of select flip-flops, one per chip, with a dedicated chain clock. The chip holding that 1 is the selected chip.

A host issues one command at a time on a valid/ready port. The commands are:
- broadcast a word;
- insert the token, or advance it;
- write or read the selected chip;
- count the chips;
- hunt for the chip that found the key.

The count is measured by how many chain clocks the token needs to come back to the controller. Each chip drives the shared found line high once it has matched the key. The hunt walks the token along the chain until that line drops. The chip that found the key releases the line when it is selected, so the position of the token at that moment is the winner. The controller then reads the winner's key words. The data bus is split into output, output-enable and input; the pad drivers sit outside the block.

Top module: `sbus_master`

## Requirements
- R1: While `rst_n` is low and after reset: `bus_ie`, `bus_oe`, `bus_cs`, `bus_doe`, `chain_out` and `chain_clk` are 0, `bus_dout` is 0, all result outputs are 0, and `cmd_ready` is 1.
- R2: Broadcast (`cmd_op` = 1) drives `cmd_data` on `bus_dout` for one cycle with `bus_ie`, `bus_cs` and `bus_doe` all high, so every attached chip stores the word.
- R3: Selected write (`cmd_op` = 4) produces the same one-cycle strobe with `bus_cs` low, so only the chip holding the token stores the word.
- R4: Token insert (`cmd_op` = 2) presents a 1 on `chain_out` and token advance (`cmd_op` = 3) presents a 0. `chain_out` is stable across the chain clock pulse and returns to 0 right after it, so exactly one 1 enters the chain.
- R5: Each chain clock pulse is high for exactly one cycle of `clk` and is followed by at least one low cycle.
- R6: Count (`cmd_op` = 6) inserts one token and advances it until `chain_in` reads 1. `res_count` then equals the number of chain clocks issued, which is the number of attached chips. This holds also when that number equals `MAX_CHIPS`.
- R7: If the token has not returned after `MAX_CHIPS` chain clocks, the count stops with `res_err` = 1 and `res_count` = 0. `res_err` is only ever 1 while `cmd_ready` is 1.
- R8: Selected read (`cmd_op` = 5) raises `bus_oe` for one cycle with `bus_doe` and `bus_cs` low, and shifts `bus_din` into the low word of `res_key`.
- R9: Hunt (`cmd_op` = 7) inserts the token and advances it until `done_in` reads 0. `res_winner` is the 0-based position of the token at that point (0 = first chip). It then reads `KEY_WORDS` words from that chip; the first word read ends in the most significant word of `res_key`.
- R10: A hunt issued while `done_in` is 0 issues no chain clock and sets `res_err`. A hunt whose found line stays high through `MAX_CHIPS` chain clocks also ends with `res_err` = 1.
- R11: `bus_ie` and `bus_oe` are never high in the same cycle.
- R12: Commands offered while `cmd_ready` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host command valid |
| cmd_op | input | 3 | Command code (see requirements) |
| cmd_data | input | DW | Word for broadcast or selected write |
| cmd_ready | output | 1 | Controller idle, command accepted when valid |
| res_count | output | DW | Chip count from the last count command |
| res_winner | output | DW | Position of the chip that found the key |
| res_key | output | DW*KEY_WORDS | Words read from the selected chip |
| res_err | output | 1 | Last count or hunt failed |
| bus_dout | output | DW | Data bus, controller to chips |
| bus_doe | output | 1 | Data bus drive enable |
| bus_din | input | DW | Data bus, chips to controller |
| bus_ie | output | 1 | Write strobe |
| bus_oe | output | 1 | Read strobe |
| bus_cs | output | 1 | Global select of all chips |
| chain_out | output | 1 | Serial token into the first chip |
| chain_in | input | 1 | Serial token back from the last chip |
| chain_clk | output | 1 | Chain shift clock |
| done_in | input | 1 | Shared found line, rests at 0 |

## Verification
Two decisions can land in the same sample cycle. In a count, the token can return on the very step that reaches `MAX_CHIPS`. In a hunt, the found line can drop on the first step, when the winner is chip 0. The bench provokes the first case with a chain exactly `MAX_CHIPS` long, which must report the count with no error, and with a chain one longer, which must time out. It provokes the second by placing the winner at position 0, which must be reported as 0 with its key read. The bench chip model judges each outcome from its own token shift register and counts chain pulses per command.

// File: rtl/sbus_pkg.sv
// Shared encodings for the search bus controller.
// Assumes: command codes are fixed by the host port contract.
package sbus_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_BCAST     = 3'd1,
        OP_TOK_START = 3'd2,
        OP_TOK_NEXT  = 3'd3,
        OP_WR_SEL    = 3'd4,
        OP_RD_SEL    = 3'd5,
        OP_COUNT     = 3'd6,
        OP_HUNT      = 3'd7
    } sbus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WR, ST_RD, ST_RDW, ST_STEP, ST_STEPW, ST_KRD, ST_KRDW
    } sbus_st_e;

    typedef enum logic [1:0] {
        MD_ONE, MD_COUNT, MD_HUNT
    } sbus_md_e;

endpackage

// File: rtl/sbus_chain_step.sv
// One token-chain step: presents a bit, pulses the chain clock once,
// drops the bit back to 0, then flags one cycle in which the returning
// chain input and found line are stable to sample.
// Assumes: go is a single-cycle request issued only while idle.
module sbus_chain_step (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic bit_in,
    output logic chain_out,
    output logic chain_clk,
    output logic fin
);

    typedef enum logic [1:0] {PH_IDLE, PH_SET, PH_HIGH, PH_SAMP} ph_e;
    ph_e ph;

    // Phase sequencer: setup, one-cycle clock pulse, release, sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            chain_out <= 1'b0;
            chain_clk <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: if (go) begin
                    chain_out <= bit_in;
                    ph        <= PH_SET;
                end
                PH_SET: begin
                    chain_clk <= 1'b1;
                    ph        <= PH_HIGH;
                end
                PH_HIGH: begin
                    chain_clk <= 1'b0;
                    chain_out <= 1'b0;
                    ph        <= PH_SAMP;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Sample window flag.
    assign fin = (ph == PH_SAMP);

endmodule

// File: rtl/sbus_word_io.sv
// Bus strobe generator: turns single-cycle write/read requests into
// registered one-cycle IE/OE strobes with data and global select.
// Assumes: requests are single-cycle and never both high.
module sbus_word_io #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic          wr_all,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_go,
    output logic          bus_ie,
    output logic          bus_oe,
    output logic          bus_cs,
    output logic          bus_doe,
    output logic [DW-1:0] bus_dout
);

    // Register all bus-facing outputs from the request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ie   <= 1'b0;
            bus_oe   <= 1'b0;
            bus_cs   <= 1'b0;
            bus_doe  <= 1'b0;
            bus_dout <= '0;
        end else begin
            bus_ie   <= wr_go;
            bus_oe   <= rd_go & ~wr_go;
            bus_cs   <= wr_go & wr_all;
            bus_doe  <= wr_go;
            bus_dout <= wr_go ? wr_data : '0;
        end
    end

endmodule

// File: rtl/sbus_master.sv
// Search bus master: broadcasts words, steps a one-hot token through
// the slave select chain, counts chips, reads the selected chip, and
// hunts the chip that raised the shared found line.
// Assumes: the chain holds no stale token when count or hunt starts.
module sbus_master #(
    parameter  int DW        = 16,
    parameter  int MAX_CHIPS = 8,
    parameter  int KEY_WORDS = 4,
    localparam int PW        = $clog2(MAX_CHIPS + 1),
    localparam int KW        = DW * KEY_WORDS,
    localparam int KCW       = $clog2(KEY_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    output logic          cmd_ready,
    output logic [DW-1:0] res_count,
    output logic [DW-1:0] res_winner,
    output logic [KW-1:0] res_key,
    output logic          res_err,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] bus_din,
    output logic          bus_ie,
    output logic          bus_oe,
    output logic          bus_cs,
    output logic          chain_out,
    input  logic          chain_in,
    output logic          chain_clk,
    input  logic          done_in
);
    import sbus_pkg::*;

    sbus_st_e       st;
    sbus_md_e       md;
    logic [PW-1:0]  pos;
    logic [KCW-1:0] kcnt;
    logic [DW-1:0]  wdata_q;
    logic           wall_q;
    logic           bit_q;
    logic           step_fin;
    logic [PW-1:0]  pos_inc;
    logic           at_limit;

    // Next position and step limit.
    assign pos_inc   = pos + 1'b1;
    assign at_limit  = (pos_inc == PW'(MAX_CHIPS));
    assign cmd_ready = (st == ST_IDLE);

    sbus_word_io #(.DW(DW)) u_io (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (st == ST_WR),
        .wr_all  (wall_q),
        .wr_data (wdata_q),
        .rd_go   ((st == ST_RD) || (st == ST_KRD)),
        .bus_ie  (bus_ie),
        .bus_oe  (bus_oe),
        .bus_cs  (bus_cs),
        .bus_doe (bus_doe),
        .bus_dout(bus_dout)
    );

    sbus_chain_step u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (st == ST_STEP),
        .bit_in   (bit_q),
        .chain_out(chain_out),
        .chain_clk(chain_clk),
        .fin      (step_fin)
    );

    // Command sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            md         <= MD_ONE;
            pos        <= '0;
            kcnt       <= '0;
            wdata_q    <= '0;
            wall_q     <= 1'b0;
            bit_q      <= 1'b0;
            res_count  <= '0;
            res_winner <= '0;
            res_key    <= '0;
            res_err    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (cmd_valid) begin
                    res_err <= 1'b0;
                    case (cmd_op)
                        OP_BCAST:     begin wdata_q <= cmd_data; wall_q <= 1'b1; st <= ST_WR; end
                        OP_WR_SEL:    begin wdata_q <= cmd_data; wall_q <= 1'b0; st <= ST_WR; end
                        OP_TOK_START: begin md <= MD_ONE; bit_q <= 1'b1; st <= ST_STEP; end
                        OP_TOK_NEXT:  begin md <= MD_ONE; bit_q <= 1'b0; st <= ST_STEP; end
                        OP_RD_SEL:    st <= ST_RD;
                        OP_COUNT:     begin md <= MD_COUNT; bit_q <= 1'b1; pos <= '0; st <= ST_STEP; end
                        OP_HUNT: begin
                            if (done_in) begin
                                md <= MD_HUNT; bit_q <= 1'b1; pos <= '0; st <= ST_STEP;
                            end else begin
                                res_err <= 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_WR:  st <= ST_IDLE;
                ST_RD:  st <= ST_RDW;
                ST_RDW: begin
                    res_key <= {res_key[KW-DW-1:0], bus_din};
                    st      <= ST_IDLE;
                end
                ST_STEP: begin
                    bit_q <= 1'b0;
                    st    <= ST_STEPW;
                end
                ST_STEPW: if (step_fin) begin
                    case (md)
                        MD_COUNT: begin
                            pos <= pos_inc;
                            if (chain_in) begin
                                res_count <= DW'(pos_inc);
                                st        <= ST_IDLE;
                            end else if (at_limit) begin
                                res_count <= '0;
                                res_err   <= 1'b1;
                                st        <= ST_IDLE;
                            end else begin
                                st <= ST_STEP;
                            end
                        end
                        MD_HUNT: begin
                            pos <= pos_inc;
                            if (!done_in) begin
                                res_winner <= DW'(pos);
                                kcnt       <= '0;
                                st         <= ST_KRD;
                            end else if (at_limit) begin
                                res_err <= 1'b1;
                                st      <= ST_IDLE;
                            end else begin
                                st <= ST_STEP;
                            end
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
                ST_KRD: st <= ST_KRDW;
                ST_KRDW: begin
                    res_key <= {res_key[KW-DW-1:0], bus_din};
                    if (kcnt == KCW'(KEY_WORDS - 1)) begin
                        st <= ST_IDLE;
                    end else begin
                        kcnt <= kcnt + 1'b1;
                        st   <= ST_KRD;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sbus_master_chk.sv
// Protocol checker for the search bus master, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module sbus_master_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_ie,
    input logic bus_oe,
    input logic bus_cs,
    input logic bus_doe,
    input logic chain_out,
    input logic chain_clk,
    input logic cmd_ready,
    input logic res_err
);

    a_r11_ie_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ie && bus_oe));

    a_r2_ie_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ie |=> !bus_ie);

    a_r8_oe_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!bus_doe && !bus_cs));

    a_r5_clk_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        chain_clk |=> !chain_clk);

    a_r4_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_clk) |-> $stable(chain_out));

    a_r4_return_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chain_clk) |-> !chain_out);

    a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> cmd_ready);

endmodule

bind sbus_master sbus_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_ie   (bus_ie),
    .bus_oe   (bus_oe),
    .bus_cs   (bus_cs),
    .bus_doe  (bus_doe),
    .chain_out(chain_out),
    .chain_clk(chain_clk),
    .cmd_ready(cmd_ready),
    .res_err  (res_err)
);

// File: tb/sim_sbus_master.sv
// Bench: behavioural chain of slave chips plus per-clock protocol monitor.
module sim_sbus_master;

    localparam int DW = 16;
    localparam int MAXC = 8;
    localparam int KWN = 4;
    localparam int NS = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [DW-1:0] cmd_data = '0;
    logic cmd_ready;
    logic [DW-1:0] res_count, res_winner;
    logic [DW*KWN-1:0] res_key;
    logic res_err;
    logic [DW-1:0] bus_dout;
    logic bus_doe;
    logic [DW-1:0] bus_din;
    logic bus_ie, bus_oe, bus_cs;
    logic chain_out, chain_in, chain_clk, done_in;

    always #4 clk = ~clk;

    sbus_master #(.DW(DW), .MAX_CHIPS(MAXC), .KEY_WORDS(KWN)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_ready(cmd_ready), .res_count(res_count),
        .res_winner(res_winner), .res_key(res_key), .res_err(res_err),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_ie(bus_ie), .bus_oe(bus_oe), .bus_cs(bus_cs),
        .chain_out(chain_out), .chain_in(chain_in), .chain_clk(chain_clk),
        .done_in(done_in)
    );

    // Slave chain model
    int n_chips = 3;
    int found_idx = -1;
    logic [NS-1:0] tok = '0;
    int wcnt [NS] = '{default: 0};
    logic [DW-1:0] wlast [NS] = '{default: 16'h0};
    int rptr [NS] = '{default: 0};

    always @(posedge chain_clk) tok <= {tok[NS-2:0], chain_out};

    assign chain_in = tok[n_chips-1];

    always_comb begin
        done_in = 1'b0;
        bus_din = '0;
        for (int i = 0; i < NS; i++) begin
            if (i < n_chips) begin
                if (i == found_idx && !tok[i]) done_in = 1'b1;
                if (bus_oe && tok[i]) bus_din = 16'hA000 | 16'(i * 16) | 16'(rptr[i] % 4);
            end
        end
    end

    always @(posedge clk) begin
        for (int i = 0; i < NS; i++) begin
            if (i < n_chips) begin
                if (bus_ie && (bus_cs || tok[i])) begin
                    wcnt[i]  = wcnt[i] + 1;
                    wlast[i] = bus_dout;
                end
                if (bus_oe && tok[i]) rptr[i] = rptr[i] + 1;
            end
        end
    end

    // Per-clock monitor
    int total = 0, bad = 0;
    int ck_rises = 0, ones_in = 0, ie_all = 0;
    logic ck_prev = 1'b0;
    bit ended = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (chain_clk && !ck_prev) begin
                ck_rises++;
                if (chain_out) ones_in++;
            end
            if (bus_ie && bus_cs) ie_all++;
            if (bus_ie && bus_oe) begin
                total++; bad++;
                $display("FAIL R11 act=ie&oe exp=exclusive");
            end
        end
        ck_prev = chain_clk;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1'b1;
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cmd(input logic [2:0] op, input logic [15:0] d);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic flush();
        repeat (NS) cmd(3'd3, 16'h0);
    endtask

    initial begin
        int c0, o0, a0, w1, w2, r;
        logic [63:0] exp;
        repeat (3) @(negedge clk);
        chk("R1 outputs", {bus_ie, bus_oe, bus_cs, bus_doe, chain_out, chain_clk, bus_dout}, 64'h0);
        chk("R1 results", {res_count, res_winner, 31'h0, res_err}, 64'h0);
        chk("R1 key", res_key, 64'h0);
        chk("R1 ready", cmd_ready, 64'h1);
        rst_n = 1'b1;

        // R2 broadcast
        a0 = ie_all; w1 = wcnt[1];
        cmd(3'd1, 16'h1234);
        cmd(3'd1, 16'h5678);
        chk("R2 cs strobes", ie_all - a0, 2);
        chk("R2 chip1 writes", wcnt[1] - w1, 2);
        chk("R2 chip0 word", wlast[0], 16'h5678);
        chk("R2 chip2 word", wlast[2], 16'h5678);

        // R6 count of 3
        c0 = ck_rises; o0 = ones_in;
        cmd(3'd6, 16'h0);
        chk("R6 count3", res_count, 3);
        chk("R6 no err", res_err, 0);
        chk("R5 pulses", ck_rises - c0, 3);
        chk("R4 one token", ones_in - o0, 1);

        // R6 boundary: chain length equals limit
        flush(); n_chips = MAXC;
        cmd(3'd6, 16'h0);
        chk("R6 count max", res_count, MAXC);
        chk("R6 max no err", res_err, 0);

        // R7 timeout
        flush(); n_chips = MAXC + 1; c0 = ck_rises;
        cmd(3'd6, 16'h0);
        chk("R7 err", res_err, 1);
        chk("R7 count zero", res_count, 0);
        chk("R7 pulses", ck_rises - c0, MAXC);

        // R3 selected writes
        flush(); n_chips = 3;
        cmd(3'd2, 16'h0);
        w1 = wcnt[1]; w2 = wcnt[2];
        cmd(3'd4, 16'hBEEF);
        chk("R3 chip0 word", wlast[0], 16'hBEEF);
        chk("R3 chip1 untouched", wcnt[1] - w1, 0);
        chk("R3 chip2 untouched", wcnt[2] - w2, 0);
        cmd(3'd3, 16'h0);
        cmd(3'd4, 16'hCAFE);
        chk("R3 chip1 word", wlast[1], 16'hCAFE);
        chk("R3 chip0 kept", wlast[0], 16'hBEEF);

        // R8 selected read, token at chip 1
        r = rptr[1];
        cmd(3'd5, 16'h0);
        chk("R8 read word", res_key[15:0], 16'hA010 | 16'(r % 4));

        // R9 hunt, winner at position 2
        flush(); n_chips = 5; found_idx = 2; r = rptr[2];
        cmd(3'd7, 16'h0);
        exp = '0;
        for (int k = 0; k < KWN; k++) exp = {exp[47:0], 16'hA020 | 16'((r + k) % 4)};
        chk("R9 winner2", res_winner, 2);
        chk("R9 no err", res_err, 0);
        chk("R9 key2", res_key, exp);

        // R9 boundary: winner on first step
        flush(); found_idx = 0; r = rptr[0];
        cmd(3'd7, 16'h0);
        exp = '0;
        for (int k = 0; k < KWN; k++) exp = {exp[47:0], 16'hA000 | 16'((r + k) % 4)};
        chk("R9 winner0", res_winner, 0);
        chk("R9 key0", res_key, exp);

        // R10 hunt with line low
        flush(); found_idx = -1; c0 = ck_rises;
        cmd(3'd7, 16'h0);
        chk("R10 err idle line", res_err, 1);
        chk("R10 no pulses", ck_rises - c0, 0);

        // R10 hunt past limit
        n_chips = 10; found_idx = 9; c0 = ck_rises;
        cmd(3'd7, 16'h0);
        chk("R10 err limit", res_err, 1);
        chk("R10 limit pulses", ck_rises - c0, MAXC);

        // R12 commands ignored while busy
        flush(); n_chips = 3; found_idx = -1; w1 = wcnt[0]; a0 = ie_all;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_data = 16'h0;
        @(negedge clk);
        cmd_op = 3'd1; cmd_data = 16'h7777;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R12 no write", wcnt[0] - w1, 0);
        chk("R12 no strobe", ie_all - a0, 0);
        chk("R12 count done", res_count, 3);

        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule